// File: doc/BRIEF.md
# Register-Access Serial Slave

This block is the serial front end of a control core. An external host drives a four-wire serial link in mode 0: chip select active low, data sampled on the clock's rising edge and changed on its falling edge. The block gives the host access to a small bank of configuration registers and a set of read-only status inputs. It also offers one-byte command strobes toward the core, and a byte-wide port onto the core's receive and transmit queues. All link inputs pass through two-flop synchronisers, and every action happens in the system clock domain. The system clock must run at least ten times faster than the serial clock.

Each transaction begins with a header byte, and the first byte the block shifts back is always a chip status byte. The header's address field and its two mode bits select one of several data phases. A configuration access can be single or burst; a burst uses an address counter that advances by one per data byte. A status read returns one byte. A queue access pops or pushes one byte per data byte. A strobe has no data phase. Raising chip select ends any transaction at once, and a byte that is only partly received is dropped.

The control machine has eight states. It leaves `ST_IDLE` for `ST_HEADER` when chip select falls. When the header completes, `ST_HEADER` goes to one of `ST_CFG_RD`, `ST_CFG_WR`, `ST_STAT_RD`, `ST_FIFO_RD`, `ST_FIFO_WR` or `ST_DRAIN`, chosen by decoding the header. A single-mode data state, and `ST_STAT_RD` always, go to `ST_DRAIN` after one data byte. Burst data states stay where they are. `ST_DRAIN` ignores every further byte. From any state, a rise of chip select returns the machine to `ST_IDLE`.

Top module: `spireg_slave`

## Requirements
- R1: Bytes move most significant bit first in both directions. The slave samples `mosi_i` on rising `sclk_i` edges and updates `miso_o` after falling edges. The first bit goes out after chip select falls.
- R2: The first byte returned in every transaction is the status byte. Bit 7 is `core_rdy_n_i`, bits 6:4 are `core_state_i`, and bits 3:0 are `rx_level_i` when header bit 7 is 1, otherwise `tx_level_i`.
- R3: In the header, bit 7 is 1 for read and 0 for write, bit 6 selects burst, and bits 5:0 are the address. Addresses below 0x30 are configuration registers. A single write commits the data byte, and a single read returns the register value.
- R4: In burst mode the address counter is loaded from the header and advances by one after each data byte until chip select rises. Reads return consecutive registers.
- R5: During every data byte of a write transaction, `miso_o` carries the status byte again, with tx-level in bits 3:0.
- R6: With burst set, addresses 0x30 to 0x3D read status register k = address - 0x30, taken from `stat_regs_i[8k+7:8k]`. Exactly one byte is returned. Further bytes return the status byte and change nothing. A burst write in this range is ignored.
- R7: With burst clear, addresses 0x30 to 0x3D are command strobes. The header alone raises `strobe_o` for exactly one clock, with `strobe_idx_o` = address - 0x30. No more than one strobe occurs per chip-select period, and any further bytes are ignored.
- R8: Strobe index 0 (address 0x30) also restores every configuration register to its default value.
- R9: A read at address 0x3F returns `rx_data_i` for each data byte and pulses `rx_pop_o` once at the first clock edge of each data byte that is started.
- R10: A write at address 0x3F pulses `tx_push_o` once for each complete data byte, with that byte on `tx_data_o`.
- R11: A rise of chip select aborts the transaction. A byte that has not been fully received is never committed, and the next transaction starts cleanly.
- R12: After reset, configuration register i holds (37*i + 11) mod 256, and `miso_o`, `strobe_o`, `rx_pop_o` and `tx_push_o` are low.
- R13: Address 0x3E, and configuration slots at or above the register count, read as 0x00 where a data byte is returned and ignore writes. A burst counter that passes the last configuration register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| core_rdy_n_i | input | 1 | Core not-ready flag for the status byte |
| core_state_i | input | 3 | Core state for the status byte |
| rx_level_i | input | 4 | Receive queue byte count |
| tx_level_i | input | 4 | Transmit queue byte count |
| stat_regs_i | input | 112 | Fourteen read-only status bytes, byte k at bits 8k+7:8k |
| rx_data_i | input | 8 | Head of the receive queue |
| rx_pop_o | output | 1 | Receive queue pop pulse |
| tx_data_o | output | 8 | Byte pushed into the transmit queue |
| tx_push_o | output | 1 | Transmit queue push pulse |
| strobe_o | output | 1 | Command strobe pulse |
| strobe_idx_o | output | 4 | Index of the strobe being issued |

## Verification
The bench goes after the overloaded 0x30 to 0x3D range. If the burst bit were decoded wrongly, a status read would fire a strobe, or a strobe would return a status register. It checks that the status byte's low nibble follows the header's read/write bit; a design that fixed the nibble before the first bit arrived would report the wrong queue level. Burst runs are checked past the last configuration register and over the queue address, where a design that prefetched too early would pop one byte too many. A chip-select rise in the middle of a byte is also checked: a design that committed partial bytes would corrupt a register.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 6;
    localparam int NUM_STAT = 14;
    localparam int STROBE_W = $clog2(NUM_STAT);

    localparam logic [ADDR_W-1:0] STAT_LO   = 6'h30;
    localparam logic [ADDR_W-1:0] STAT_HI   = 6'h3D;
    localparam logic [ADDR_W-1:0] FIFO_ADDR = 6'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_CFG_RD,
        ST_CFG_WR,
        ST_STAT_RD,
        ST_FIFO_RD,
        ST_FIFO_WR,
        ST_DRAIN
    } xact_state_e;

    function automatic logic [BYTE_W-1:0] cfg_default(input int idx);
        logic [31:0] t;
        t = idx * 37 + 11;
        return t[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else begin
                stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spireg_shift.sv
module spireg_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              csn_s,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              cs_start_o,
    output logic              cs_end_o,
    output logic              first_rise_o,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              hdr_msb_o,
    output logic              miso_o
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic              csn_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] shreg_q;
    logic              byte0_q;
    logic              rise;
    logic              fall;

    assign cs_start_o   = csn_q & ~csn_s;
    assign cs_end_o     = ~csn_q & csn_s;
    assign rise         = ~csn_s & sclk_s & ~sclk_q;
    assign fall         = ~csn_s & ~sclk_s & sclk_q;
    assign first_rise_o = rise && (bit_cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= 1'b0;
            csn_q       <= 1'b1;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            byte0_q     <= 1'b1;
            byte_done_o <= 1'b0;
            rx_byte_o   <= '0;
            hdr_msb_o   <= 1'b0;
            miso_o      <= 1'b0;
        end else begin
            sclk_q      <= sclk_s;
            csn_q       <= csn_s;
            byte_done_o <= 1'b0;
            if (csn_s) begin
                bit_cnt_q <= '0;
                byte0_q   <= 1'b1;
                miso_o    <= 1'b0;
            end else begin
                if (cs_start_o) begin
                    bit_cnt_q <= '0;
                    miso_o    <= tx_byte_i[BYTE_W-1];
                end
                if (rise) begin
                    shreg_q   <= {shreg_q[BYTE_W-3:0], mosi_s};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (bit_cnt_q == '0 && byte0_q) begin
                        hdr_msb_o <= mosi_s;
                    end
                    if (bit_cnt_q == LAST_BIT) begin
                        byte_done_o <= 1'b1;
                        rx_byte_o   <= {shreg_q, mosi_s};
                        byte0_q     <= 1'b0;
                    end
                end
                if (fall) begin
                    miso_o <= tx_byte_i[LAST_BIT - bit_cnt_q];
                end
            end
        end
    end

    // R1: a completed byte always follows a sampled rising edge
    a_r1_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> $past(rise));

    // R11: chip select high keeps the serial output quiet
    a_r11_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_s) && csn_s |-> !miso_o);

endmodule

// File: rtl/spireg_regs.sv
module spireg_regs
    import spireg_pkg::*;
#(
    parameter int N_REGS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [BYTE_W-1:0] q [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= cfg_default(g);
            end else if (restore_i) begin
                q[g] <= cfg_default(g);
            end else if (wr_en_i && wr_addr_i == ADDR_W'(g)) begin
                q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_addr_i == ADDR_W'(i)) begin
                rd_data_o = q[i];
            end
        end
    end

    // R8: a restore returns the end registers to their defaults
    a_r8_restore_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (q[0] == cfg_default(0)) && (q[N_REGS-1] == cfg_default(N_REGS-1)));

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int N_REGS = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       csn_i,
    input  logic                       mosi_i,
    output logic                       miso_o,
    input  logic                       core_rdy_n_i,
    input  logic [2:0]                 core_state_i,
    input  logic [3:0]                 rx_level_i,
    input  logic [3:0]                 tx_level_i,
    input  logic [NUM_STAT*BYTE_W-1:0] stat_regs_i,
    input  logic [BYTE_W-1:0]          rx_data_i,
    output logic                       rx_pop_o,
    output logic [BYTE_W-1:0]          tx_data_o,
    output logic                       tx_push_o,
    output logic                       strobe_o,
    output logic [STROBE_W-1:0]        strobe_idx_o
);

    logic sclk_s, mosi_s, csn_s;
    logic cs_start, cs_end, first_rise, byte_done, hdr_msb;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] status_live;
    logic [BYTE_W-1:0] tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    xact_state_e       state_q, state_d, hdr_target;

    logic              hdr_burst;
    logic [ADDR_W-1:0] hdr_addr;
    logic              hdr_in_stat;
    logic [STROBE_W-1:0] stat_idx;
    logic [BYTE_W-1:0] stat_byte;
    logic              hdr_is_strobe;
    logic              use_status;

    logic              reg_wr_en;
    logic              reg_restore;
    logic [ADDR_W-1:0] reg_rd_addr;
    logic [BYTE_W-1:0] reg_rd_data;

    spireg_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, mosi_i, csn_i}),
        .q_o   ({sclk_s, mosi_s, csn_s})
    );

    spireg_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (sclk_s),
        .mosi_s       (mosi_s),
        .csn_s        (csn_s),
        .tx_byte_i    (tx_byte),
        .cs_start_o   (cs_start),
        .cs_end_o     (cs_end),
        .first_rise_o (first_rise),
        .byte_done_o  (byte_done),
        .rx_byte_o    (rx_byte),
        .hdr_msb_o    (hdr_msb),
        .miso_o       (miso_o)
    );

    spireg_regs #(.N_REGS(N_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .restore_i (reg_restore),
        .wr_en_i   (reg_wr_en),
        .wr_addr_i (addr_q),
        .wr_data_i (rx_byte),
        .rd_addr_i (reg_rd_addr),
        .rd_data_o (reg_rd_data)
    );

    // header fields and decode
    assign hdr_burst   = rx_byte[6];
    assign hdr_addr    = rx_byte[ADDR_W-1:0];
    assign hdr_in_stat = (hdr_addr >= STAT_LO) && (hdr_addr <= STAT_HI);
    assign stat_idx    = STROBE_W'(hdr_addr - STAT_LO);
    assign hdr_is_strobe = hdr_in_stat && !hdr_burst;

    always_comb begin
        stat_byte = '0;
        for (int k = 0; k < NUM_STAT; k++) begin
            if (stat_idx == STROBE_W'(k)) begin
                stat_byte = stat_regs_i[k*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        if (hdr_addr == FIFO_ADDR) begin
            hdr_target = rx_byte[7] ? ST_FIFO_RD : ST_FIFO_WR;
        end else if (hdr_in_stat) begin
            hdr_target = (hdr_burst && rx_byte[7]) ? ST_STAT_RD : ST_DRAIN;
        end else if (hdr_addr < STAT_LO) begin
            hdr_target = rx_byte[7] ? ST_CFG_RD : ST_CFG_WR;
        end else begin
            hdr_target = ST_DRAIN;
        end
    end

    // status byte, low nibble chosen by the header's direction bit
    assign status_live = {core_rdy_n_i, core_state_i, hdr_msb ? rx_level_i : tx_level_i};

    always_comb begin
        unique case (state_q)
            ST_CFG_RD, ST_STAT_RD, ST_FIFO_RD: use_status = 1'b0;
            default:                           use_status = 1'b1;
        endcase
    end
    assign tx_byte = use_status ? status_live : tx_q;

    // register file hooks
    assign reg_wr_en   = (state_q == ST_CFG_WR) && byte_done;
    assign reg_restore = (state_q == ST_HEADER) && byte_done && hdr_is_strobe && (stat_idx == '0);
    assign reg_rd_addr = (state_q == ST_HEADER) ? hdr_addr : addr_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_start) state_d = ST_HEADER;
            ST_HEADER:  if (byte_done) state_d = hdr_target;
            ST_CFG_RD,
            ST_CFG_WR,
            ST_FIFO_RD,
            ST_FIFO_WR: if (byte_done && !burst_q) state_d = ST_DRAIN;
            ST_STAT_RD: if (byte_done) state_d = ST_DRAIN;
            ST_DRAIN:   state_d = ST_DRAIN;
        endcase
        if (cs_end) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q         <= '0;
            addr_q       <= '0;
            burst_q      <= 1'b0;
            rx_pop_o     <= 1'b0;
            tx_push_o    <= 1'b0;
            tx_data_o    <= '0;
            strobe_o     <= 1'b0;
            strobe_idx_o <= '0;
        end else begin
            rx_pop_o  <= 1'b0;
            tx_push_o <= 1'b0;
            strobe_o  <= 1'b0;
            unique case (state_q)
                ST_HEADER: begin
                    if (byte_done) begin
                        addr_q  <= hdr_addr;
                        burst_q <= hdr_burst;
                        unique case (hdr_target)
                            ST_CFG_RD:  tx_q <= reg_rd_data;
                            ST_STAT_RD: tx_q <= stat_byte;
                            ST_FIFO_RD: tx_q <= rx_data_i;
                            default:    tx_q <= '0;
                        endcase
                        if (hdr_is_strobe) begin
                            strobe_o     <= 1'b1;
                            strobe_idx_o <= stat_idx;
                        end
                    end
                end
                ST_CFG_RD: begin
                    if (byte_done) begin
                        addr_q <= addr_q + 1'b1;
                        tx_q   <= reg_rd_data;
                    end
                end
                ST_CFG_WR: begin
                    if (byte_done) begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_FIFO_RD: begin
                    if (first_rise) begin
                        rx_pop_o <= 1'b1;
                    end
                    if (byte_done) begin
                        tx_q <= rx_data_i;
                    end
                end
                ST_FIFO_WR: begin
                    if (byte_done) begin
                        tx_push_o <= 1'b1;
                        tx_data_o <= rx_byte;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R11: deselect always returns to idle
    a_r11_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> (state_q == ST_IDLE));

    // R7: strobes are single-cycle pulses with an index in range
    a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
    a_r7_strobe_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (strobe_idx_o < STROBE_W'(NUM_STAT)));

    // R9: queue pops are single-cycle pulses
    a_r9_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |=> !rx_pop_o);

    // R10: queue pushes are single-cycle pulses
    a_r10_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_o |=> !tx_push_o);

    // R6: a status read lasts a single data byte
    a_r6_status_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAT_RD) && byte_done && !cs_end |=> (state_q == ST_DRAIN));

endmodule

// File: tb/spireg_slave_bench.sv
module spireg_slave_bench;
    import spireg_pkg::*;

    localparam int  NREG = 48;
    localparam time HALF = 80ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5ns clk = ~clk;

    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, miso;
    logic [NUM_STAT*8-1:0] stat_regs;
    logic [7:0] rx_data, tx_data;
    logic rx_pop, tx_push, strobe;
    logic [STROBE_W-1:0] strobe_idx;

    spireg_slave #(.N_REGS(NREG)) u_spireg_slave (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .miso_o(miso), .core_rdy_n_i(1'b0), .core_state_i(3'b101),
        .rx_level_i(4'h9), .tx_level_i(4'h3), .stat_regs_i(stat_regs),
        .rx_data_i(rx_data), .rx_pop_o(rx_pop), .tx_data_o(tx_data),
        .tx_push_o(tx_push), .strobe_o(strobe), .strobe_idx_o(strobe_idx)
    );

    localparam logic [7:0] ST_RD = 8'h59;
    localparam logic [7:0] ST_WR = 8'h53;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] model [NREG];
    logic [7:0] rx_mem [64];
    int rx_ptr = 0, pops = 0, pushes = 0, strobes = 0;
    logic [7:0] push_log [16];
    logic [STROBE_W-1:0] last_idx;
    logic [7:0] tb [8];
    logic [7:0] rb [8];

    for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
        assign stat_regs[k*8 +: 8] = 8'hA0 + 8'(k);
    end
    assign rx_data = rx_mem[rx_ptr[5:0]];

    always @(posedge clk) begin
        if (rx_pop) begin rx_ptr <= rx_ptr + 1; pops <= pops + 1; end
        if (tx_push) begin push_log[pushes[3:0]] <= tx_data; pushes <= pushes + 1; end
        if (strobe) begin strobes <= strobes + 1; last_idx <= strobe_idx; end
    end

    function automatic logic [7:0] dflt(input int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) begin
            mosi = d[b];
            #(HALF);
            r[b] = miso;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic txn(input int n);
        csn = 1'b0;
        for (int i = 0; i < n; i++) xbyte(tb[i], rb[i]);
        #(HALF);
        csn = 1'b1;
        #(HALF * 2);
    endtask

    task automatic rd1(input logic [5:0] a, output logic [7:0] v);
        tb[0] = {2'b10, a}; tb[1] = 8'h00;
        txn(2);
        v = rb[1];
    endtask

    task automatic wr1(input logic [5:0] a, input logic [7:0] v);
        tb[0] = {2'b00, a}; tb[1] = v;
        txn(2);
        if (a < 6'(NREG)) model[a] = v;
    endtask

    initial begin
        #1.5ms;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int p0, s0, q0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) rx_mem[i] = 8'h40 + 8'(i * 3);
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        #40ns; rst_n = 1'b1; #40ns;

        // R12: reset state
        chk("R12 miso", 32'(miso), 0);
        chk("R12 pulses", {strobe, rx_pop, tx_push}, 0);
        rd1(6'h00, v); chk("R12 default r0", v, dflt(0));
        rd1(6'h2F, v); chk("R12 default r47", v, dflt(47));
        chk("R2 status on read", rb[0], ST_RD);

        // R3 / R1 / R2: single write then read
        wr1(6'h05, 8'hA5);
        chk("R2 status on write", rb[0], ST_WR);
        rd1(6'h05, v); chk("R3 single rw", v, 8'hA5);
        wr1(6'h06, 8'h01);
        rd1(6'h06, v); chk("R1 msb first low bit", v, 8'h01);
        wr1(6'h06, 8'h80);
        rd1(6'h06, v); chk("R1 msb first high bit", v, 8'h80);

        // R4 / R5: burst write then burst read
        tb[0] = 8'h50; tb[1] = 8'h11; tb[2] = 8'h22; tb[3] = 8'h33; tb[4] = 8'h44;
        txn(5);
        for (int i = 1; i < 5; i++) begin
            model[16 + i - 1] = tb[i];
            chk("R5 status per burst write byte", rb[i], ST_WR);
        end
        tb[0] = 8'hD0; for (int i = 1; i < 5; i++) tb[i] = 8'h00;
        txn(5);
        for (int i = 1; i < 5; i++) chk("R4 burst read", rb[i], model[16 + i - 1]);

        // R13: burst read past last register
        tb[0] = 8'hEE; tb[1] = 0; tb[2] = 0; tb[3] = 0;
        txn(4);
        chk("R13 burst r46", rb[1], model[46]);
        chk("R13 burst r47", rb[2], model[47]);
        chk("R13 past end reads zero", rb[3], 8'h00);

        // R6: status register read, then extra byte
        s0 = strobes;
        tb[0] = 8'hF2; tb[1] = 0; tb[2] = 0;
        txn(3);
        chk("R6 status reg 2", rb[1], 8'hA2);
        chk("R6 extra byte returns status", rb[2], ST_RD);
        tb[0] = 8'h73; tb[1] = 8'h5A;
        txn(2);
        chk("R6 burst write ignored no strobe", strobes, s0);

        // R7: strobes, with extra bytes
        tb[0] = 8'h35; tb[1] = 8'h35; tb[2] = 8'h35;
        txn(3);
        chk("R7 one strobe per select", strobes, s0 + 1);
        chk("R7 strobe index", 32'(last_idx), 5);
        tb[0] = 8'hBD;
        txn(1);
        chk("R7 read-bit strobe index", 32'(last_idx), 13);
        chk("R7 strobe count", strobes, s0 + 2);

        // R8: reset strobe restores defaults
        wr1(6'h03, 8'h99);
        tb[0] = 8'h30;
        txn(1);
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        chk("R8 strobe index 0", 32'(last_idx), 0);
        rd1(6'h03, v); chk("R8 restored r3", v, dflt(3));
        rd1(6'h05, v); chk("R8 restored r5", v, dflt(5));

        // R9: queue reads
        p0 = pops; q0 = rx_ptr;
        tb[0] = 8'hBF; tb[1] = 0; tb[2] = 0;
        txn(3);
        chk("R9 single pop value", rb[1], rx_mem[q0]);
        chk("R9 single pop count", pops, p0 + 1);
        p0 = pops; q0 = rx_ptr;
        tb[0] = 8'hFF; tb[1] = 0; tb[2] = 0; tb[3] = 0;
        txn(4);
        for (int i = 1; i < 4; i++) chk("R9 burst pop value", rb[i], rx_mem[q0 + i - 1]);
        chk("R9 burst pop count", pops, p0 + 3);

        // R10: queue writes
        tb[0] = 8'h7F; tb[1] = 8'hC1; tb[2] = 8'hC2; tb[3] = 8'hC3;
        txn(4);
        chk("R10 push count", pushes, 3);
        chk("R10 push data", {push_log[0], push_log[1], push_log[2]}, 32'hC1C2C3);

        // R11: abort mid data byte
        csn = 1'b0;
        xbyte(8'h07, v);
        for (int b = 7; b >= 4; b--) begin
            mosi = 1'b0; #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
        end
        #(HALF); csn = 1'b1; #(HALF * 2);
        rd1(6'h07, v); chk("R11 partial byte not committed", v, dflt(7));
        chk("R11 next transaction status", rb[0], ST_RD);

        // R13: address 0x3E ignored
        p0 = pops; s0 = strobes;
        tb[0] = 8'h3E; tb[1] = 8'hFF;
        txn(2);
        tb[0] = 8'hBE; tb[1] = 8'h00;
        txn(2);
        chk("R13 0x3E no side effect", {pops, strobes, pushes}, {p0, s0, 3});

        // R3 / R4: constrained random configuration traffic
        for (int it = 0; it < 30; it++) begin
            int a, n;
            bit burst, rd;
            burst = 1'($urandom_range(0, 1));
            rd    = 1'($urandom_range(0, 1));
            n     = burst ? $urandom_range(1, 4) : 1;
            a     = $urandom_range(0, NREG - n);
            tb[0] = {rd, burst, 6'(a)};
            for (int i = 1; i <= n; i++) tb[i] = 8'($urandom());
            txn(n + 1);
            for (int i = 1; i <= n; i++) begin
                if (rd) chk("R4 random read", rb[i], model[a + i - 1]);
                else model[a + i - 1] = tb[i];
            end
        end
        for (int i = 0; i < NREG; i += 7) begin
            rd1(6'(i), v); chk("R3 random final", v, model[i]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule